// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This unit sits inside a small 8-bit processor core and owns the moment at which a pending interrupt takes over the instruction stream. It watches two active-low request lines, one that is maskable and level-sensitive and one that cannot be masked and is caught on its falling edge. It accepts a request only when the core signals that an instruction has just finished. Once it accepts a request, it takes control of the memory port for five consecutive cycles. In those cycles it saves the return address and the status byte on the stack, sets the interrupt-disable flag, and fetches the address of the service routine from a fixed two-byte vector.

The unit also runs the opposite sequence when the core asks it to return from a service routine. It pulls the status byte, which brings back the earlier disable flag, and then pulls the saved program counter. It owns the 8-bit stack pointer and the disable flag. Two single-cycle inputs let the core set or clear that flag directly. Memory is modelled as a single port with combinational read data, so each access takes exactly one cycle.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the unit is idle (`busy` low, no memory access), the disable flag `irq_dis` is 1 and the stack pointer `sp_val` is 0xFF.
- R2: A sequence starts only in the cycle after `insn_done` (entry) or `rti_start` (return) was high while idle. A request that arrives without a boundary strobe leaves `busy` low.
- R3: While idle, a low `irq_req_n` at a boundary starts an entry only if `irq_dis` is 0. It is accepted again at every later boundary while it stays low and the flag is clear. While the flag is 1 it is ignored.
- R4: A falling edge on `nmi_req_n` is latched and starts an entry at the next boundary, whatever the value of `irq_dis`. Holding the line low does not start a second entry.
- R5: When both requests are pending at one boundary, the non-maskable one is served. The maskable request stays pending and is served at a later boundary once the flag is clear again.
- R6: An entry writes three bytes to the stack page 0x01 in this order: program counter high byte at 0x0100+SP, low byte at SP-1, and status byte at SP-2. Bit 2 of the saved status byte holds the disable flag as it was before the entry. The stack pointer drops by one after each write.
- R7: An entry sets `irq_dis` to 1 from its first cycle onward.
- R8: The new program counter is read little-endian from 0xFFFA/0xFFFB for the non-maskable request and from 0xFFFE/0xFFFF for the maskable one. It is presented on `pc_new` with `pc_load` in the last entry cycle.
- R9: A return increments the stack pointer before each of three reads. It loads the status byte first and restores `irq_dis` from its bit 2. It then reads the program counter low byte and then the high byte, and loads `{high, low}` on `pc_new`.
- R10: While idle, a pulse on `set_dis` or `clr_dis` changes `irq_dis` one cycle later. If both are high, set wins.
- R11: An entry keeps `busy` high for exactly 5 cycles and a return for exactly 3. During these cycles exactly one of `mem_rd`/`mem_wr` is high in each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_n | input | 1 | Maskable request, active low, level |
| nmi_req_n | input | 1 | Non-maskable request, active low, falling edge |
| insn_done | input | 1 | Instruction boundary strobe |
| rti_start | input | 1 | Start the return sequence |
| set_dis | input | 1 | Set the disable flag |
| clr_dis | input | 1 | Clear the disable flag |
| pc_in | input | 16 | Current program counter (address of next instruction) |
| status_in | input | 8 | Status byte; bit 2 is replaced by the internal flag |
| rd_data | input | 8 | Memory read data, valid in the cycle of `mem_rd` |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| sp_dec | output | 1 | Stack pointer decrement strobe |
| sp_val | output | 8 | Current stack pointer |
| pc_load | output | 1 | Load `pc_new` into the program counter |
| pc_new | output | 16 | New program counter |
| status_load | output | 1 | Load `status_new` into the status register |
| status_new | output | 8 | Restored status byte |
| irq_dis | output | 1 | Interrupt-disable flag |
| busy | output | 1 | Sequence in progress |

## Verification
The bench attacks the maskable line held low across boundaries. It expects re-entry once the flag is clear and no entry while it is set. A design that treats the line as edge-triggered misses the re-entry, and one that ignores the flag nests the service routine. It holds the non-maskable line low across several boundaries, which shows whether a design re-triggers on level instead of edge. It raises both requests at once, which exposes a design with the wrong priority or one that drops the maskable request. The saved status byte and the stack addresses are compared byte by byte, which catches a swapped push order, an off-by-one pointer, or a design that saves the disable flag after setting it instead of before.

// File: rtl/ies_pkg.sv
package ies_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PUSH_HI,
        S_PUSH_LO,
        S_PUSH_ST,
        S_VEC_LO,
        S_VEC_HI,
        S_PULL_ST,
        S_PULL_LO,
        S_PULL_HI
    } seq_state_e;

    typedef struct packed {
        seq_state_e          st;
        logic                use_nmi;
        logic [ADDR_W-1:0]   pc_save;
        logic [DATA_W-1:0]   stat_save;
        logic [DATA_W-1:0]   lo_byte;
        logic                iflag;
    } seq_regs_t;
endpackage

// File: rtl/ies_nmi_latch.sv
module ies_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    input  logic consume,
    output logic pending
);
    typedef struct packed {
        logic prev;
        logic pend;
    } latch_t;

    latch_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.prev = req_n;
        nxt_d.pend = (cur_q.pend & ~consume) | (cur_q.prev & ~req_n);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.prev <= 1'b1;
            cur_q.pend <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign pending = cur_q.pend;
endmodule

// File: rtl/ies_stack_ptr.sv
module ies_stack_ptr #(
    parameter int          PTR_W  = 8,
    parameter logic [7:0]  PAGE   = 8'h01,
    parameter logic [PTR_W-1:0] SP_RST = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic                 pull,
    output logic [PTR_W-1:0]     sp,
    output logic [PTR_W+7:0]     addr
);
    logic [PTR_W-1:0] sp_q, sp_d, sp_inc;

    assign sp_inc = sp_q + 1'b1;

    always_comb begin
        sp_d = sp_q;
        if (push)      sp_d = sp_q - 1'b1;
        else if (pull) sp_d = sp_inc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sp_q <= SP_RST;
        else        sp_q <= sp_d;
    end

    assign sp   = sp_q;
    assign addr = pull ? {PAGE, sp_inc} : {PAGE, sp_q};
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import ies_pkg::*;
#(
    parameter logic [15:0] NMI_VEC    = 16'hFFFA,
    parameter logic [15:0] IRQ_VEC    = 16'hFFFE,
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter logic [7:0]  SP_RESET   = 8'hFF,
    parameter int          IFLAG_BIT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req_n,
    input  logic              nmi_req_n,
    input  logic              insn_done,
    input  logic              rti_start,
    input  logic              set_dis,
    input  logic              clr_dis,
    input  logic [15:0]       pc_in,
    input  logic [7:0]        status_in,
    input  logic [7:0]        rd_data,
    output logic [15:0]       mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    output logic              sp_dec,
    output logic [7:0]        sp_val,
    output logic              pc_load,
    output logic [15:0]       pc_new,
    output logic              status_load,
    output logic [7:0]        status_new,
    output logic              irq_dis,
    output logic              busy
);
    seq_regs_t   r_q, r_d;
    logic        nmi_pend, nmi_take;
    logic        accept, ret_go;
    logic        push, pull;
    logic [15:0] stk_addr, vec_base;

    ies_nmi_latch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_n   (nmi_req_n),
        .consume (nmi_take),
        .pending (nmi_pend)
    );

    ies_stack_ptr #(.PTR_W(8), .PAGE(STACK_PAGE), .SP_RST(SP_RESET)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pull  (pull),
        .sp    (sp_val),
        .addr  (stk_addr)
    );

    assign ret_go   = (r_q.st == S_IDLE) && rti_start;
    assign accept   = (r_q.st == S_IDLE) && insn_done && !rti_start &&
                      (nmi_pend || (!irq_req_n && !r_q.iflag));
    assign nmi_take = accept && nmi_pend;
    assign vec_base = r_q.use_nmi ? NMI_VEC : IRQ_VEC;

    always_comb begin
        r_d         = r_q;
        push        = 1'b0;
        pull        = 1'b0;
        mem_rd      = 1'b0;
        mem_wr      = 1'b0;
        mem_wdata   = '0;
        mem_addr    = '0;
        pc_load     = 1'b0;
        pc_new      = '0;
        status_load = 1'b0;
        status_new  = '0;
        case (r_q.st)
            S_IDLE: begin
                if (ret_go) begin
                    r_d.st = S_PULL_ST;
                end else if (accept) begin
                    r_d.st                   = S_PUSH_HI;
                    r_d.use_nmi              = nmi_pend;
                    r_d.pc_save              = pc_in;
                    r_d.stat_save            = status_in;
                    r_d.stat_save[IFLAG_BIT] = r_q.iflag;
                    r_d.iflag                = 1'b1;
                end else if (set_dis) begin
                    r_d.iflag = 1'b1;
                end else if (clr_dis) begin
                    r_d.iflag = 1'b0;
                end
            end
            S_PUSH_HI: begin
                push      = 1'b1;
                mem_wr    = 1'b1;
                mem_addr  = stk_addr;
                mem_wdata = r_q.pc_save[15:8];
                r_d.st    = S_PUSH_LO;
            end
            S_PUSH_LO: begin
                push      = 1'b1;
                mem_wr    = 1'b1;
                mem_addr  = stk_addr;
                mem_wdata = r_q.pc_save[7:0];
                r_d.st    = S_PUSH_ST;
            end
            S_PUSH_ST: begin
                push      = 1'b1;
                mem_wr    = 1'b1;
                mem_addr  = stk_addr;
                mem_wdata = r_q.stat_save;
                r_d.st    = S_VEC_LO;
            end
            S_VEC_LO: begin
                mem_rd      = 1'b1;
                mem_addr    = vec_base;
                r_d.lo_byte = rd_data;
                r_d.st      = S_VEC_HI;
            end
            S_VEC_HI: begin
                mem_rd   = 1'b1;
                mem_addr = vec_base + 16'd1;
                pc_load  = 1'b1;
                pc_new   = {rd_data, r_q.lo_byte};
                r_d.st   = S_IDLE;
            end
            S_PULL_ST: begin
                pull        = 1'b1;
                mem_rd      = 1'b1;
                mem_addr    = stk_addr;
                status_load = 1'b1;
                status_new  = rd_data;
                r_d.iflag   = rd_data[IFLAG_BIT];
                r_d.st      = S_PULL_LO;
            end
            S_PULL_LO: begin
                pull        = 1'b1;
                mem_rd      = 1'b1;
                mem_addr    = stk_addr;
                r_d.lo_byte = rd_data;
                r_d.st      = S_PULL_HI;
            end
            S_PULL_HI: begin
                pull     = 1'b1;
                mem_rd   = 1'b1;
                mem_addr = stk_addr;
                pc_load  = 1'b1;
                pc_new   = {rd_data, r_q.lo_byte};
                r_d.st   = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st        <= S_IDLE;
            r_q.use_nmi   <= 1'b0;
            r_q.pc_save   <= '0;
            r_q.stat_save <= '0;
            r_q.lo_byte   <= '0;
            r_q.iflag     <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sp_dec  = push;
    assign irq_dis = r_q.iflag;
    assign busy    = (r_q.st != S_IDLE);
endmodule

// File: rtl/ies_checker.sv
module ies_checker #(
    parameter logic [7:0] STACK_PAGE = 8'h01
) (
    input logic        clk,
    input logic        rst_n,
    input logic        insn_done,
    input logic        rti_start,
    input logic [15:0] mem_addr,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic        pc_load,
    input logic [7:0]  sp_val,
    input logic        irq_dis,
    input logic        busy
);
    // R2: a sequence begins only after a boundary or return strobe
    a_r2_start_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(insn_done || rti_start));

    // R11: one memory access per busy cycle
    a_r11_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $onehot({mem_rd, mem_wr}));

    // R11: idle unit leaves the bus alone
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr && !pc_load));

    // R7: flag is already set while pushing
    a_r7_masked_during_push: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> irq_dis);

    // R6: pointer post-decrements on every push
    a_r6_sp_post_dec: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (sp_val == $past(sp_val) - 8'd1));

    // R9: pointer pre-increments on every pull
    a_r9_sp_pre_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_addr[15:8] == STACK_PAGE) |=> (sp_val == $past(sp_val) + 8'd1));

    // R6: writes land in the stack page only
    a_r6_write_page: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr[15:8] == STACK_PAGE));
endmodule

bind irq_entry_seq ies_checker #(.STACK_PAGE(STACK_PAGE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_done (insn_done),
    .rti_start (rti_start),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .pc_load   (pc_load),
    .sp_val    (sp_val),
    .irq_dis   (irq_dis),
    .busy      (busy)
);

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        irq_req_n, nmi_req_n, insn_done, rti_start, set_dis, clr_dis;
    logic [15:0] pc_in;
    logic [7:0]  status_in;
    logic [7:0]  rd_data;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic        sp_dec;
    logic [7:0]  sp_val;
    logic        pc_load;
    logic [15:0] pc_new;
    logic        status_load;
    logic [7:0]  status_new;
    logic        irq_dis, busy;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0]  stk [0:255];
    logic [7:0]  v_nl, v_nh, v_il, v_ih;
    logic [15:0] got_pc;
    logic [7:0]  got_st;
    logic        exp_i;
    logic [7:0]  exp_sp;

    always #5 clk = ~clk;

    irq_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req_n(irq_req_n), .nmi_req_n(nmi_req_n),
        .insn_done(insn_done), .rti_start(rti_start), .set_dis(set_dis), .clr_dis(clr_dis),
        .pc_in(pc_in), .status_in(status_in), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .sp_dec(sp_dec), .sp_val(sp_val), .pc_load(pc_load), .pc_new(pc_new),
        .status_load(status_load), .status_new(status_new), .irq_dis(irq_dis), .busy(busy)
    );

    always_comb begin
        if (mem_addr[15:8] == 8'h01) rd_data = stk[mem_addr[7:0]];
        else begin
            case (mem_addr)
                16'hFFFA: rd_data = v_nl;
                16'hFFFB: rd_data = v_nh;
                16'hFFFE: rd_data = v_il;
                16'hFFFF: rd_data = v_ih;
                default:  rd_data = 8'h00;
            endcase
        end
    end

    always @(posedge clk) begin
        if (mem_wr && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
        if (pc_load) got_pc <= pc_new;
        if (status_load) got_st <= status_new;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic no_entry(input string req);
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        chk(req, {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk(req, {31'd0, busy}, 32'd0);
    endtask

    task automatic enter(input logic use_nmi, input logic [15:0] pc, input logic [7:0] st);
        int cnt;
        logic [7:0] exp_st;
        logic [7:0] a1, a2;
        exp_st = (st & 8'hFB) | {5'd0, exp_i, 2'd0};
        a1 = exp_sp - 8'd1;
        a2 = exp_sp - 8'd2;
        pc_in = pc;
        status_in = st;
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        cnt = 0;
        while (busy) begin
            cnt++;
            @(negedge clk);
        end
        chk("R11 entry length", cnt, 5);
        chk("R6 pc high pushed first", {24'd0, stk[exp_sp]}, {24'd0, pc[15:8]});
        chk("R6 pc low pushed second", {24'd0, stk[a1]}, {24'd0, pc[7:0]});
        chk("R6 status pushed third", {24'd0, stk[a2]}, {24'd0, exp_st});
        if (use_nmi) chk("R8 R4 nmi vector", {16'd0, got_pc}, {16'd0, v_nh, v_nl});
        else         chk("R8 R3 irq vector", {16'd0, got_pc}, {16'd0, v_ih, v_il});
        chk("R7 flag set on entry", {31'd0, irq_dis}, 32'd1);
        exp_i = 1'b1;
        exp_sp = exp_sp - 8'd3;
        chk("R6 sp after entry", {24'd0, sp_val}, {24'd0, exp_sp});
    endtask

    task automatic leave();
        int cnt;
        logic [7:0] e_st;
        logic [15:0] e_pc;
        e_st = stk[exp_sp + 8'd1];
        e_pc = {stk[exp_sp + 8'd3], stk[exp_sp + 8'd2]};
        rti_start = 1'b1;
        @(negedge clk);
        rti_start = 1'b0;
        cnt = 0;
        while (busy) begin
            cnt++;
            @(negedge clk);
        end
        chk("R11 return length", cnt, 3);
        chk("R9 status restored", {24'd0, got_st}, {24'd0, e_st});
        chk("R9 pc restored", {16'd0, got_pc}, {16'd0, e_pc});
        chk("R9 flag restored", {31'd0, irq_dis}, {31'd0, e_st[2]});
        exp_i = e_st[2];
        exp_sp = exp_sp + 8'd3;
        chk("R9 sp after return", {24'd0, sp_val}, {24'd0, exp_sp});
    endtask

    task automatic nmi_edge();
        nmi_req_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        nmi_req_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_cli();
        clr_dis = 1'b1;
        @(negedge clk);
        clr_dis = 1'b0;
        chk("R10 clear flag", {31'd0, irq_dis}, 32'd0);
        exp_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd2024);
        irq_req_n = 1'b1; nmi_req_n = 1'b1; insn_done = 1'b0; rti_start = 1'b0;
        set_dis = 1'b0; clr_dis = 1'b0; pc_in = '0; status_in = '0;
        v_nl = 8'h34; v_nh = 8'h12; v_il = 8'h78; v_ih = 8'h56;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy low", {31'd0, busy}, 32'd0);
        chk("R1 flag set", {31'd0, irq_dis}, 32'd1);
        chk("R1 sp", {24'd0, sp_val}, 32'hFF);
        chk("R1 no access", {30'd0, mem_rd, mem_wr}, 32'd0);
        exp_i = 1'b1;
        exp_sp = 8'hFF;

        // R3 masked request ignored
        irq_req_n = 1'b0;
        no_entry("R3 masked while flag set");
        pulse_cli();
        enter(1'b0, 16'hC0DE, 8'hA1);
        no_entry("R3 held off inside routine");
        leave();
        // R3 level: still low, taken again
        enter(1'b0, 16'h4321, 8'h5A);
        irq_req_n = 1'b1;
        leave();

        // R10 set flag
        set_dis = 1'b1;
        @(negedge clk);
        set_dis = 1'b0;
        chk("R10 set flag", {31'd0, irq_dis}, 32'd1);
        exp_i = 1'b1;

        // R2 edge without boundary does not start
        nmi_req_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 no start without boundary", {31'd0, busy}, 32'd0);
        // R4 unmasked, flag is set
        enter(1'b1, 16'h8001, 8'h00);
        no_entry("R4 no retrigger while held low");
        leave();
        nmi_req_n = 1'b1;
        @(negedge clk);

        // R5 priority
        pulse_cli();
        irq_req_n = 1'b0;
        nmi_edge();
        enter(1'b1, 16'h2222, 8'h33);
        leave();
        enter(1'b0, 16'h2222, 8'h33);
        irq_req_n = 1'b1;
        leave();

        // random mix
        for (int k = 0; k < 24; k++) begin
            logic [15:0] rpc;
            logic [7:0]  rst_b;
            v_nl = 8'($urandom); v_nh = 8'($urandom);
            v_il = 8'($urandom); v_ih = 8'($urandom);
            rpc = 16'($urandom);
            rst_b = 8'($urandom);
            if ($urandom % 2 == 0) begin
                nmi_edge();
                enter(1'b1, rpc, rst_b);
            end else begin
                pulse_cli();
                irq_req_n = 1'b0;
                enter(1'b0, rpc, rst_b);
                irq_req_n = 1'b1;
            end
            leave();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule